// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames from an upstream MAC byte stream and stores them, one after another, in a circular buffer held in a byte-wide memory reached through a plain write port. In front of every stored frame it places a 4-byte header made of a 16-bit status word and a 16-bit length word, both little-endian. Each header starts on a 4-byte boundary, and all offsets wrap modulo a ring length chosen by a 2-bit size select.

The host consumes frames by moving a read-pointer register. That register holds the true read offset minus 16. The block compares the two pointers to raise a buffer-empty flag, and it refuses any frame that would run into data the host has not yet read. Three write-one-to-clear interrupt bits report a good frame, a frame that carries error flags, and a dropped frame.

While a frame is being copied, the length field of its header slot reads 0xFFF0. The real header is written only once the last payload byte is in memory.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring length is BASE_LEN shifted left by `size_sel` (0 to 3, giving 8, 16, 32 or 64 KB by default). The memory region is that length plus 16 bytes. Every write address and the write pointer stay below the ring length, wrapping modulo it.
- R2: For a frame that starts at offset S, the status low byte goes to S, the status high byte (always 0) to S+1, the length low byte to S+2 and the length high byte to S+3. Payload byte i goes to (S+4+i) mod ring length.
- R3: The stored length equals the number of bytes the MAC delivered for the frame, including its trailing 4-byte CRC.
- R4: In the status low byte, bit 0 is set exactly when `mac_flags` was zero at end of frame. Bits 1 to 5 copy `mac_flags[0]` to `mac_flags[4]` (alignment, CRC, too long, runt, invalid symbol). Bits 6 and 7 are zero.
- R5: The length field of the slot at the write pointer holds 0xFFF0 (byte 0xF0 at +2, 0xFF at +3) while the receiver is enabled and idle, and during a copy. It is written after enable and after every committed frame. The real header is written after the last payload byte.
- R6: After a committed frame, the write pointer moves to (S + round-up-to-4(length+4)) mod ring length. It is always a multiple of 4.
- R7: `rdp_q` returns the last value written through `rdp_we`. The true read offset is (`rdp_q`+16) mod ring length. At reset and while the receiver is disabled, `rdp_q` is 2^OW-16, which is true offset 0.
- R8: `buf_empty` is 1 exactly when the true read offset equals the write pointer, one cycle after either pointer changes.
- R9: While `rx_en` is 0, the write pointer and `rdp_q` hold their reset values, and a frame in progress is abandoned without writing a header.
- R10: `int_stat` bit 0 is set when a frame with no flags is committed, bit 1 when a flagged frame is committed, and bit 4 on a drop. Writing 1 in `int_clr_mask` with `int_clr_we` clears a bit, and a set in the same cycle wins. Bits 2 and 3 read 0.
- R11: Let free space be (true read offset − write pointer) mod ring length, taken as the full ring length when the two are equal. A frame whose rounded footprint (round-up-to-4(length+4)) is not below free space is dropped. No payload byte is written at or past the read offset, no header is written, the write pointer is unchanged and `int_stat` bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 resets both pointers |
| size_sel | input | 2 | Ring length select (BASE_LEN << size_sel) |
| mac_valid | input | 1 | A frame byte is present on `mac_data` |
| mac_sof | input | 1 | First byte of a frame |
| mac_eof | input | 1 | Last byte of a frame |
| mac_data | input | 8 | Frame byte |
| mac_flags | input | 5 | Error flags, valid with `mac_eof` |
| rdp_we | input | 1 | Host write strobe for the read-pointer register |
| rdp_wdata | input | OW | New read-pointer value (true offset − 16) |
| rdp_q | output | OW | Read-pointer register |
| buf_empty | output | 1 | Ring holds no unread frame |
| int_clr_we | input | 1 | Interrupt clear strobe |
| int_clr_mask | input | 5 | Write-one-to-clear mask |
| int_stat | output | 5 | Interrupt status (bits 0, 1, 4) |
| wr_ptr | output | OW | Hardware write pointer (next header offset) |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | OW+1 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |

## Verification
The assertions assume the MAC delivers a `mac_sof` only while the writer is idle, so new frames must not arrive during the six cycles of header and sentinel writes. They also assume `size_sel` changes only while the receiver is disabled and its last write has drained. The bench keeps to this by driving one frame at a time, waiting a dozen cycles before the next, and changing the size only a few cycles after lowering `rx_en`. The host read pointer is moved only to 4-byte-aligned offsets that the block has already committed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_SEN_LO, ST_SEN_HI, ST_IDLE, ST_DATA, ST_DROP,
    ST_HDR0, ST_HDR1, ST_HDR2, ST_HDR3
  } rxr_state_e;

  localparam logic [15:0] RXR_SENTINEL = 16'hFFF0;
  localparam int RXR_HDR_BYTES = 4;
  localparam int RXR_RD_BIAS   = 16;
  localparam int RXR_IRQ_W     = 5;
  localparam int RXR_FLAG_W    = 5;
endpackage

// File: rtl/rxr_ptr.sv
module rxr_ptr
  import rxr_pkg::*;
#(
  parameter int BASE_LEN = 8192,
  parameter int OW       = $clog2(BASE_LEN) + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [1:0]    size_sel,
  input  logic          rdp_we,
  input  logic [OW-1:0] rdp_wdata,
  input  logic          wp_load,
  input  logic [OW-1:0] wp_next,
  output logic [OW-1:0] wp,
  output logic [OW-1:0] rdp_q,
  output logic [OW-1:0] ring_mask,
  output logic [OW:0]   free_bytes,
  output logic          buf_empty
);
  localparam int LW = OW + 1;
  localparam logic [OW-1:0] RDP_RESET = {OW{1'b0}} - OW'(RXR_RD_BIAS);

  logic [LW-1:0] ring_len;
  logic [OW-1:0] rd_true;
  logic [OW-1:0] gap;

  assign ring_len   = LW'(BASE_LEN) << size_sel;
  assign ring_mask  = OW'(ring_len - LW'(1));
  assign rd_true    = (rdp_q + OW'(RXR_RD_BIAS)) & ring_mask;
  assign gap        = (rd_true - wp) & ring_mask;
  assign free_bytes = (gap == '0) ? ring_len : {1'b0, gap};

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      wp    <= '0;
      rdp_q <= RDP_RESET;
    end else begin
      if (wp_load) wp <= wp_next;
      if (rdp_we)  rdp_q <= rdp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) buf_empty <= 1'b1;
    else     buf_empty <= (rd_true == wp);
  end

  p_wp_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    wp[1:0] == 2'b00);
  p_wp_in_ring_r1: assert property (@(posedge clk) disable iff (rst)
    (wp & ~ring_mask) == '0);
  p_off_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (wp == '0 && rdp_q == RDP_RESET));
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq
  import rxr_pkg::*;
#(
  parameter int NB = RXR_IRQ_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set,
  input  logic          clr_we,
  input  logic [NB-1:0] clr_mask,
  output logic [NB-1:0] stat
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)                         q <= 1'b0;
      else if (set[i])                 q <= 1'b1;
      else if (clr_we && clr_mask[i])  q <= 1'b0;
    end
    assign stat[i] = q;

    p_set_r10: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> stat[i]);
    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[i] && !set[i]) |=> !stat[i]);
  end
endmodule

// File: rtl/rxr_wr.sv
module rxr_wr
  import rxr_pkg::*;
#(
  parameter int OW   = 16,
  parameter int AW   = OW + 1,
  parameter int LENW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_en,
  input  logic                  mac_valid,
  input  logic                  mac_sof,
  input  logic                  mac_eof,
  input  logic [7:0]            mac_data,
  input  logic [RXR_FLAG_W-1:0] mac_flags,
  input  logic [OW-1:0]         wp,
  input  logic [OW-1:0]         ring_mask,
  input  logic [OW:0]           free_bytes,
  output logic                  wp_load,
  output logic [OW-1:0]         wp_next,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  set_ok,
  output logic                  set_err,
  output logic                  set_ovf
);
  localparam int CW = (LENW > OW ? LENW : OW) + 2;

  rxr_state_e            state;
  logic [OW-1:0]         start;
  logic [LENW-1:0]       cnt;
  logic [RXR_FLAG_W-1:0] flags;

  logic            in_idle, take, fits_byte, fits_end, commit;
  logic [OW-1:0]   base, byte_off;
  logic [LENW-1:0] cur;
  logic [CW-1:0]   need_byte, need_end, free_c, step;
  logic [7:0]      status_lo;

  assign in_idle   = (state == ST_IDLE);
  assign base      = in_idle ? wp : start;
  assign cur       = in_idle ? '0 : cnt;
  assign take      = rx_en && mac_valid && ((in_idle && mac_sof) || state == ST_DATA);
  assign free_c    = CW'(free_bytes);
  assign need_byte = CW'(cur) + CW'(RXR_HDR_BYTES + 1);
  assign need_end  = (need_byte + CW'(3)) & ~CW'(3);
  assign fits_byte = need_byte < free_c;
  assign fits_end  = need_end < free_c;
  assign byte_off  = (base + OW'(RXR_HDR_BYTES) + OW'(cur)) & ring_mask;

  assign set_ovf   = take && (!fits_byte || (mac_eof && !fits_end));
  assign commit    = rx_en && (state == ST_HDR3);
  assign set_ok    = commit && (flags == '0);
  assign set_err   = commit && (flags != '0);
  assign step      = (CW'(cnt) + CW'(RXR_HDR_BYTES + 3)) & ~CW'(3);
  assign wp_next   = (start + OW'(step)) & ring_mask;
  assign wp_load   = commit;
  assign status_lo = {2'b00, flags, (flags == '0)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      start     <= '0;
      cnt       <= '0;
      flags     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (!rx_en) begin
        state <= ST_OFF;
      end else begin
        case (state)
          ST_OFF: state <= ST_SEN_LO;
          ST_SEN_LO: begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'((wp + OW'(2)) & ring_mask);
            mem_wdata <= RXR_SENTINEL[7:0];
            state     <= ST_SEN_HI;
          end
          ST_SEN_HI: begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'((wp + OW'(3)) & ring_mask);
            mem_wdata <= RXR_SENTINEL[15:8];
            state     <= ST_IDLE;
          end
          ST_IDLE, ST_DATA: begin
            if (take) begin
              if (in_idle) start <= wp;
              if (!fits_byte) begin
                state <= mac_eof ? ST_IDLE : ST_DROP;
              end else begin
                mem_we    <= 1'b1;
                mem_addr  <= AW'(byte_off);
                mem_wdata <= mac_data;
                cnt       <= cur + LENW'(1);
                if (mac_eof) begin
                  flags <= mac_flags;
                  state <= fits_end ? ST_HDR0 : ST_IDLE;
                end else begin
                  state <= ST_DATA;
                end
              end
            end
          end
          ST_DROP: if (mac_valid && mac_eof) state <= ST_IDLE;
          ST_HDR0: begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'(start);
            mem_wdata <= status_lo;
            state     <= ST_HDR1;
          end
          ST_HDR1: begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'((start + OW'(1)) & ring_mask);
            mem_wdata <= 8'h00;
            state     <= ST_HDR2;
          end
          ST_HDR2: begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'((start + OW'(2)) & ring_mask);
            mem_wdata <= cnt[7:0];
            state     <= ST_HDR3;
          end
          ST_HDR3: begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'((start + OW'(3)) & ring_mask);
            mem_wdata <= cnt[15:8];
            state     <= ST_SEN_LO;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  p_ovf_keeps_wp_r11: assert property (@(posedge clk) disable iff (rst)
    set_ovf |=> wp == $past(wp));
  p_wr_in_ring_r1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr <= AW'(ring_mask)));
  p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({set_ok, set_err, set_ovf}) <= 1);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int BASE_LEN = 8192,
  parameter int LENW     = 16,
  localparam int OW      = $clog2(BASE_LEN) + 3,
  localparam int AW      = OW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_en,
  input  logic [1:0]            size_sel,
  input  logic                  mac_valid,
  input  logic                  mac_sof,
  input  logic                  mac_eof,
  input  logic [7:0]            mac_data,
  input  logic [RXR_FLAG_W-1:0] mac_flags,
  input  logic                  rdp_we,
  input  logic [OW-1:0]         rdp_wdata,
  output logic [OW-1:0]         rdp_q,
  output logic                  buf_empty,
  input  logic                  int_clr_we,
  input  logic [RXR_IRQ_W-1:0]  int_clr_mask,
  output logic [RXR_IRQ_W-1:0]  int_stat,
  output logic [OW-1:0]         wr_ptr,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [7:0]            mem_wdata
);
  logic          wp_load, set_ok, set_err, set_ovf;
  logic [OW-1:0] wp_next, ring_mask;
  logic [OW:0]   free_bytes;

  rxr_ptr #(.BASE_LEN(BASE_LEN), .OW(OW)) u_ptr (
    .clk(clk), .rst(rst), .rx_en(rx_en), .size_sel(size_sel),
    .rdp_we(rdp_we), .rdp_wdata(rdp_wdata),
    .wp_load(wp_load), .wp_next(wp_next),
    .wp(wr_ptr), .rdp_q(rdp_q), .ring_mask(ring_mask),
    .free_bytes(free_bytes), .buf_empty(buf_empty)
  );

  rxr_wr #(.OW(OW), .AW(AW), .LENW(LENW)) u_wr (
    .clk(clk), .rst(rst), .rx_en(rx_en),
    .mac_valid(mac_valid), .mac_sof(mac_sof), .mac_eof(mac_eof),
    .mac_data(mac_data), .mac_flags(mac_flags),
    .wp(wr_ptr), .ring_mask(ring_mask), .free_bytes(free_bytes),
    .wp_load(wp_load), .wp_next(wp_next),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .set_ok(set_ok), .set_err(set_err), .set_ovf(set_ovf)
  );

  rxr_irq #(.NB(RXR_IRQ_W)) u_irq (
    .clk(clk), .rst(rst),
    .set({set_ovf, 1'b0, 1'b0, set_err, set_ok}),
    .clr_we(int_clr_we), .clr_mask(int_clr_mask), .stat(int_stat)
  );
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 64;
  localparam int OW = $clog2(BASE) + 3;
  localparam int AW = OW + 1;

  logic clk = 0, rst = 1, rx_en = 0;
  logic [1:0] size_sel = 0;
  logic mac_valid = 0, mac_sof = 0, mac_eof = 0;
  logic [7:0] mac_data = 0;
  logic [4:0] mac_flags = 0;
  logic rdp_we = 0;
  logic [OW-1:0] rdp_wdata = 0;
  logic [OW-1:0] rdp_q, wr_ptr;
  logic buf_empty, int_clr_we = 0, mem_we;
  logic [4:0] int_clr_mask = 0, int_stat;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem [0:(1<<AW)-1];

  int tests = 0, fails = 0, addr_bad = 0;
  int exp_wp = 0, rd_true = 0, ring = BASE;

  rx_ring_writer #(.BASE_LEN(BASE)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (int'(mem_addr) >= ring) addr_bad <= addr_bad + 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(int off);
    return mem[AW'(off % ring)];
  endfunction

  task automatic send_frame(int len, logic [4:0] fl, int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      mac_valid = 1; mac_sof = (i == 0); mac_eof = (i == len - 1);
      mac_data = 8'(seed + i * 7); mac_flags = fl;
    end
    @(negedge clk);
    mac_valid = 0; mac_sof = 0; mac_eof = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk); int_clr_we = 1; int_clr_mask = 5'h1F;
    @(negedge clk); int_clr_we = 0; int_clr_mask = 0;
    @(negedge clk);
    chk(int_stat == 0, "R10 w1c clear", int'(int_stat), 0);
  endtask

  task automatic set_rd(int true_off);
    @(negedge clk); rdp_we = 1; rdp_wdata = OW'(true_off - 16);
    @(negedge clk); rdp_we = 0;
  endtask

  task automatic restart(int sel);
    @(negedge clk); rx_en = 0;
    repeat (3) @(negedge clk);
    size_sel = 2'(sel); ring = BASE << sel;
    repeat (2) @(negedge clk);
    rx_en = 1;
    repeat (6) @(negedge clk);
    exp_wp = 0; rd_true = 0;
    chk(rd(2) === 8'hF0 && rd(3) === 8'hFF, "R5 sentinel after enable", int'({rd(3), rd(2)}), 16'hFFF0);
  endtask

  task automatic run_frame(int len, logic [4:0] fl, bit consume);
    int s, fr, need, nw, bad;
    logic [7:0] st;
    s = exp_wp;
    fr = (rd_true - s) & (ring - 1);
    if (fr == 0) fr = ring;
    need = ((len + 7) / 4) * 4;
    send_frame(len, fl, len * 3 + ring);
    repeat (12) @(negedge clk);
    if (need < fr) begin
      nw = (s + need) % ring;
      st = {2'b00, fl, (fl == 0)};
      chk(rd(s) === st, "R4 status low byte", int'(rd(s)), int'(st));
      chk(rd(s + 1) === 8'h00, "R2 status high byte", int'(rd(s + 1)), 0);
      chk({rd(s + 3), rd(s + 2)} === 16'(len), "R3 stored length", int'({rd(s + 3), rd(s + 2)}), len);
      bad = 0;
      for (int i = 0; i < len; i++)
        if (rd(s + 4 + i) !== 8'(len * 3 + ring + i * 7)) bad++;
      chk(bad == 0, "R2 payload placement", bad, 0);
      chk(rd(nw + 2) === 8'hF0 && rd(nw + 3) === 8'hFF, "R5 next slot sentinel",
          int'({rd(nw + 3), rd(nw + 2)}), 16'hFFF0);
      chk(int'(wr_ptr) == nw, "R6 write pointer advance", int'(wr_ptr), nw);
      chk(int_stat == ((fl == 0) ? 5'b00001 : 5'b00010), "R10 frame irq", int'(int_stat),
          (fl == 0) ? 1 : 2);
      chk(buf_empty == 0, "R8 not empty after frame", int'(buf_empty), 0);
      exp_wp = nw;
      clear_irq();
      if (consume) begin
        set_rd(nw);
        repeat (3) @(negedge clk);
        chk(buf_empty == 1, "R8 empty after consume", int'(buf_empty), 1);
        chk(int'(rdp_q) == ((nw - 16) & ((1 << OW) - 1)), "R7 read pointer register",
            int'(rdp_q), (nw - 16) & ((1 << OW) - 1));
        rd_true = nw;
      end
    end else begin
      chk(int'(wr_ptr) == s, "R11 write pointer kept on drop", int'(wr_ptr), s);
      chk(int_stat[4] == 1, "R11 overflow irq", int'(int_stat), 16);
      chk(rd(s + 2) === 8'hF0 && rd(s + 3) === 8'hFF, "R11 no header on drop",
          int'({rd(s + 3), rd(s + 2)}), 16'hFFF0);
      clear_irq();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(wr_ptr == 0, "R9 reset write pointer", int'(wr_ptr), 0);
    chk(int'(rdp_q) == (1 << OW) - 16, "R7 reset read pointer", int'(rdp_q), (1 << OW) - 16);
    chk(buf_empty == 1, "R8 reset empty", int'(buf_empty), 1);
    chk(int_stat == 0, "R10 reset irq", int'(int_stat), 0);
    chk(mem_we == 0, "R9 no write while disabled", int'(mem_we), 0);

    for (int sel = 0; sel < 4; sel++) begin
      restart(sel);
      for (int len = 1; len <= 24; len++)
        run_frame(len, (len % 6 == 0) ? 5'(1 << (len % 5)) : 5'b0, 1'b1);
      run_frame(BASE - 8, 5'b0, 1'b1);
      run_frame(BASE - 7, 5'b10000, 1'b1);
      run_frame(100, 5'b0, 1'b1);
    end

    // R11 overflow boundaries with a host that never reads
    restart(0);
    run_frame(20, 5'b0, 1'b0);
    run_frame(20, 5'b0, 1'b0);
    run_frame(20, 5'b0, 1'b0);
    run_frame(11, 5'b0, 1'b0);
    run_frame(8, 5'b0, 1'b0);
    run_frame(1, 5'b0, 1'b0);

    // R5 sentinel visible during a copy
    restart(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      mac_valid = 1; mac_sof = (i == 0); mac_eof = 0; mac_data = 8'(8'hA0 + i);
    end
    @(negedge clk); mac_valid = 0; mac_sof = 0;
    repeat (5) @(negedge clk);
    chk(rd(2) === 8'hF0 && rd(3) === 8'hFF, "R5 sentinel during copy", int'({rd(3), rd(2)}), 16'hFFF0);
    chk(rd(4) === 8'hA0, "R2 first payload byte during copy", int'(rd(4)), 16'hA0);
    for (int i = 3; i < 5; i++) begin
      @(negedge clk);
      mac_valid = 1; mac_eof = (i == 4); mac_data = 8'(8'hA0 + i);
    end
    @(negedge clk); mac_valid = 0; mac_eof = 0;
    repeat (12) @(negedge clk);
    chk({rd(3), rd(2)} === 16'd5, "R3 length after copy", int'({rd(3), rd(2)}), 5);
    chk(wr_ptr == 12, "R6 pointer after copy", int'(wr_ptr), 12);
    clear_irq();

    // R9 disable in the middle of a frame
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      mac_valid = 1; mac_sof = (i == 0); mac_eof = 0; mac_data = 8'h55;
    end
    @(negedge clk); mac_valid = 0; mac_sof = 0; rx_en = 0;
    repeat (3) @(negedge clk);
    chk(wr_ptr == 0, "R9 disable clears write pointer", int'(wr_ptr), 0);
    chk(int'(rdp_q) == (1 << OW) - 16, "R9 disable resets read pointer", int'(rdp_q), (1 << OW) - 16);
    chk(buf_empty == 1, "R9 empty while disabled", int'(buf_empty), 1);
    chk(rd(14) === 8'hF0 && rd(15) === 8'hFF, "R9 abandoned frame has no header",
        int'({rd(15), rd(14)}), 16'hFFF0);
    chk(int_stat == 0, "R9 abandoned frame raises no irq", int'(int_stat), 0);
    rx_en = 1;
    repeat (6) @(negedge clk);
    chk(rd(2) === 8'hF0 && rd(3) === 8'hFF, "R5 sentinel rewritten on enable", int'({rd(3), rd(2)}), 16'hFFF0);

    chk(addr_bad == 0, "R1 writes inside ring", addr_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule